// File: doc/BRIEF.md
# Match-Compare Watchdog Timer with Escalating Reset

This block is a watchdog that runs a 16-bit free-running up-counter on a slow low-frequency clock. It compares the low bits of the count with a programmed match value and raises an interrupt each time they are equal. A match never clears the counter. A programmable number of top counter bits can be left out of the compare, which shortens the match period to a power of two between 2 and 65536 slow cycles. Software feeds the watchdog by clearing the interrupt. If two matches go unhandled, the next match produces a one-cycle reset pulse in the slow domain. The block then stays idle until its slow-domain reset is applied.

Software reaches the block through a simple single-cycle register interface on the fast system clock. Configuration is protected by a two-bit lock that needs two separate writes to open. Configuration values, feed requests and counter loads cross into the slow domain through synchronizers. A change therefore takes effect a few slow cycles after the write. The counter value and the pending flag cross back for reading.

Register map (address on `bus_addr`): 0 control (bit 0 enable), 1 match value (16 bits), 2 ignore count (bits 3:0), 3 lock (bits 1:0), 4 interrupt (write bit 0 = 1 to feed; read bit 0 = pending), 5 interrupt mask (bit 0, 1 passes the interrupt), 6 counter (read the live count; write to load it).

Top module: `match_wdt`

## Requirements
- R1: After reset the registers read as follows:
  - address 6 (counter) is 0.
  - address 1 (match) is 4096.
  - address 2 (ignore count) is 0.
  - address 3 (lock) is 3, so the block starts locked.
  - address 0 (enable) is 0.
  - address 4 (pending) is 0.
  - `irq` and `wdt_rst` are low.
- R2: The counter is 16 bits wide and advances by one on every slow clock edge while enabled. It wraps from 0xFFFF to 0. While disabled it holds its value.
- R3: With ignore count N (0 to 15), a match happens when the low 16−N bits of the counter equal the low 16−N bits of the match register. Upper bits on both sides play no part in the compare.
- R4: A match does not clear or reload the counter. Counting continues straight through it.
- R5: The unhandled-match count saturates at 2. A match that finds two unhandled matches produces the reset pulse. Starting from count 0 with match M, the third match therefore occurs when the count is M + 2·2^(16−N), and no earlier match produces a reset.
- R6: `wdt_rst` is high for exactly one slow cycle. After it, the counter freezes and no further pulse appears until `rst_lf` is applied.
- R7: Writing 1 to bit 0 of address 4 zeroes the unhandled-match count. Address 4 bit 0 reads 1 while that count is non-zero.
- R8: `irq` equals the pending flag ANDed with the mask bit at address 5. A cleared mask keeps `irq` low and still allows the reset.
- R9: The lock is two bits, and any set bit makes the lock active:
  - Writing a 1 to a lock bit sets it.
  - Writing 0 to bit 0 clears it.
  - Writing 0 to bit 1 clears it only if bit 0 was already clear before that write.
  - So two writes of 0 are needed to open the lock from 3.
  - While the lock is active, writes to addresses 0, 1 and 2 are ignored.
- R10: Every accepted write of 1 to the enable bit also zeroes the unhandled-match count.
- R11: A write to address 6 loads the counter only while the watchdog is disabled. While it is enabled, the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | System clock for the register interface |
| rst_sys | input | 1 | Synchronous active-high reset, system domain |
| clk_lf | input | 1 | Slow low-frequency counter clock |
| rst_lf | input | 1 | Synchronous active-high reset, slow domain |
| wr_en | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address for writes and reads |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for `bus_addr` |
| irq | output | 1 | Masked watchdog interrupt |
| wdt_rst | output | 1 | One-slow-cycle device reset request |

## Verification
The bench runs the counter in short periods of 2 and 16 slow cycles and reads where it froze after the reset pulse. A block that reset on the second match, cleared the counter on a match, or compared the ignored upper match bits would stop at a count other than 38 (or 6). It opens the lock one step at a time. A single-write unlock, or a lock that fails to hold writes to the match register, would change what the match register reads back. Counter loads are tried both while the watchdog is enabled and while it is disabled, which catches a load that is not gated by enable. The bench also feeds the watchdog more often than the match period. An escalation count that ignored feeds, or an enable that left a stale pending flag, would show as a reset pulse or a pending bit where none is due.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int CNT_W    = 16;
    localparam int IGN_W    = $clog2(CNT_W);
    localparam int ADDR_W   = 3;
    localparam int LOCK_W   = 2;
    localparam int PEND_MAX = 2;
    localparam int PEND_W   = $clog2(PEND_MAX + 1);

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL  = 3'd0,
        A_MATCH = 3'd1,
        A_IGN   = 3'd2,
        A_LOCK  = 3'd3,
        A_INTR  = 3'd4,
        A_MASK  = 3'd5,
        A_COUNT = 3'd6
    } reg_addr_e;

    typedef struct packed {
        logic             en;
        logic [CNT_W-1:0] match;
        logic [IGN_W-1:0] ign;
    } wdt_cfg_t;

    typedef enum logic {ST_RUN, ST_HALT} core_st_e;

    function automatic logic [CNT_W-1:0] bin2gray(input logic [CNT_W-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [CNT_W-1:0] gray2bin(input logic [CNT_W-1:0] g);
        logic [CNT_W-1:0] b;
        b[CNT_W-1] = g[CNT_W-1];
        for (int i = CNT_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    // Compare mask keeping the low CNT_W-ign bits.
    function automatic logic [CNT_W-1:0] cmp_mask(input logic [IGN_W-1:0] ign);
        return {CNT_W{1'b1}} >> ign;
    endfunction

    // Bit 1 may only drop once bit 0 was already clear.
    function automatic logic [LOCK_W-1:0] lock_next(input logic [LOCK_W-1:0] cur,
                                                    input logic [LOCK_W-1:0] req);
        logic [LOCK_W-1:0] nxt;
        nxt[0] = req[0];
        nxt[1] = req[1] | (cur[1] & cur[0]);
        return nxt;
    endfunction

endpackage

// File: rtl/wdt_cdc_sync.sv
module wdt_cdc_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int MATCH_RST = 4096
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [CNT_W-1:0]    wdata,
    output logic [CNT_W-1:0]    rdata,
    output wdt_cfg_t            cfg,
    output logic                clr_tgl,
    output logic                load_tgl,
    output logic [CNT_W-1:0]    load_val,
    input  logic                pend_s,
    input  logic [CNT_W-1:0]    gray_s,
    output logic                irq
);
    logic [LOCK_W-1:0] lock_q;
    logic              mask_q;
    logic              locked;
    logic [CNT_W-1:0]  cnt_rd;

    assign locked = |lock_q;
    assign cnt_rd = gray2bin(gray_s);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg      <= '{en: 1'b0, match: CNT_W'(MATCH_RST), ign: '0};
            lock_q   <= '1;
            mask_q   <= 1'b0;
            clr_tgl  <= 1'b0;
            load_tgl <= 1'b0;
            load_val <= '0;
        end else if (wr_en) begin
            case (reg_addr_e'(addr))
                A_CTRL: if (!locked) begin
                    cfg.en <= wdata[0];
                    if (wdata[0]) clr_tgl <= ~clr_tgl;
                end
                A_MATCH: if (!locked) cfg.match <= wdata;
                A_IGN:   if (!locked) cfg.ign <= wdata[IGN_W-1:0];
                A_LOCK:  lock_q <= lock_next(lock_q, wdata[LOCK_W-1:0]);
                A_INTR:  if (wdata[0]) clr_tgl <= ~clr_tgl;
                A_MASK:  mask_q <= wdata[0];
                A_COUNT: begin
                    load_val <= wdata;
                    load_tgl <= ~load_tgl;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (reg_addr_e'(addr))
            A_CTRL:  rdata[0] = cfg.en;
            A_MATCH: rdata = cfg.match;
            A_IGN:   rdata[IGN_W-1:0] = cfg.ign;
            A_LOCK:  rdata[LOCK_W-1:0] = lock_q;
            A_INTR:  rdata[0] = pend_s;
            A_MASK:  rdata[0] = mask_q;
            A_COUNT: rdata = cnt_rd;
            default: rdata = '0;
        endcase
    end

    assign irq = pend_s & mask_q;

    // R9: bit 1 of the lock never opens before bit 0
    a_r9_unlock_order: assert property (@(posedge clk) disable iff (rst)
        $fell(lock_q[1]) |-> !$past(lock_q[0]));

    // R9: locked writes leave the match value untouched
    a_r9_locked_match: assert property (@(posedge clk) disable iff (rst)
        (locked && wr_en && addr == A_MATCH) |=> $stable(cfg.match));

    // R10: an accepted enable write launches a feed event
    a_r10_enable_feeds: assert property (@(posedge clk) disable iff (rst)
        (!locked && wr_en && addr == A_CTRL && wdata[0]) |=> (clr_tgl != $past(clr_tgl)));
endmodule

// File: rtl/wdt_core.sv
module wdt_core
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  wdt_cfg_t          cfg_s,
    input  logic              clr_tgl_s,
    input  logic              load_tgl_s,
    input  logic [CNT_W-1:0]  load_val,
    output logic [CNT_W-1:0]  cnt_gray,
    output logic              pend,
    output logic              wdt_rst
);
    core_st_e          state;
    logic [CNT_W-1:0]  cnt;
    logic [PEND_W-1:0] pend_cnt;
    logic              clr_d, load_d;
    logic              clr_ev, load_ev, hit;

    assign clr_ev  = clr_tgl_s ^ clr_d;
    assign load_ev = load_tgl_s ^ load_d;
    assign hit     = (state == ST_RUN) && cfg_s.en &&
                     (((cnt ^ cfg_s.match) & cmp_mask(cfg_s.ign)) == '0);
    assign pend    = (pend_cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_RUN;
            cnt      <= '0;
            pend_cnt <= '0;
            clr_d    <= 1'b0;
            load_d   <= 1'b0;
            wdt_rst  <= 1'b0;
            cnt_gray <= '0;
        end else begin
            clr_d    <= clr_tgl_s;
            load_d   <= load_tgl_s;
            wdt_rst  <= 1'b0;
            cnt_gray <= bin2gray(cnt);
            if (state == ST_RUN) begin
                if (cfg_s.en)     cnt <= cnt + 1'b1;
                else if (load_ev) cnt <= load_val;
                if (hit && pend_cnt == PEND_W'(PEND_MAX) && !clr_ev) begin
                    wdt_rst <= 1'b1;
                    state   <= ST_HALT;
                end else if (clr_ev) begin
                    pend_cnt <= hit ? PEND_W'(1) : '0;
                end else if (hit) begin
                    pend_cnt <= pend_cnt + 1'b1;
                end
            end
        end
    end

    // R2: enabled counter steps by one, wrapping at the top
    a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && cfg_s.en) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

    // R11: a disabled counter only moves on a load event
    a_r11_hold_disabled: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && !cfg_s.en && !load_ev) |=> $stable(cnt));

    // R5: unhandled count never exceeds its cap
    a_r5_pend_cap: assert property (@(posedge clk) disable iff (rst)
        pend_cnt <= PEND_W'(PEND_MAX));

    // R5: reset only follows two unhandled matches
    a_r5_third_match: assert property (@(posedge clk) disable iff (rst)
        $rose(wdt_rst) |-> ($past(pend_cnt) == PEND_W'(PEND_MAX)));

    // R6: pulse lasts one cycle
    a_r6_one_cycle: assert property (@(posedge clk) disable iff (rst)
        wdt_rst |=> !wdt_rst);

    // R6: after the pulse the counter is frozen
    a_r6_halt_freeze: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HALT) |=> ($stable(cnt) && !wdt_rst));
endmodule

// File: rtl/match_wdt.sv
module match_wdt
    import wdt_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int MATCH_RST   = 4096
) (
    input  logic              clk_sys,
    input  logic              rst_sys,
    input  logic              clk_lf,
    input  logic              rst_lf,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [CNT_W-1:0]  rd_data,
    output logic              irq,
    output logic              wdt_rst
);
    localparam int       CFG_W   = $bits(wdt_cfg_t);
    localparam wdt_cfg_t CFG_RST = '{en: 1'b0, match: CNT_W'(MATCH_RST), ign: '0};

    wdt_cfg_t         cfg_sys, cfg_lf;
    logic [CFG_W-1:0] cfg_lf_vec;
    logic             clr_tgl, load_tgl;
    logic [1:0]       tgl_lf;
    logic [CNT_W-1:0] load_val, cnt_gray;
    logic             pend_lf;
    logic [CNT_W:0]   back_sys;

    wdt_regs #(.MATCH_RST(MATCH_RST)) u_regs (
        .clk      (clk_sys),
        .rst      (rst_sys),
        .wr_en    (wr_en),
        .addr     (bus_addr),
        .wdata    (wr_data),
        .rdata    (rd_data),
        .cfg      (cfg_sys),
        .clr_tgl  (clr_tgl),
        .load_tgl (load_tgl),
        .load_val (load_val),
        .pend_s   (back_sys[CNT_W]),
        .gray_s   (back_sys[CNT_W-1:0]),
        .irq      (irq)
    );

    wdt_cdc_sync #(.W(CFG_W), .STAGES(SYNC_STAGES), .RST_VAL(CFG_RST)) u_sync_cfg (
        .clk (clk_lf), .rst (rst_lf), .d (cfg_sys), .q (cfg_lf_vec)
    );
    assign cfg_lf = wdt_cfg_t'(cfg_lf_vec);

    wdt_cdc_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_sync_evt (
        .clk (clk_lf), .rst (rst_lf), .d ({load_tgl, clr_tgl}), .q (tgl_lf)
    );

    wdt_core u_core (
        .clk        (clk_lf),
        .rst        (rst_lf),
        .cfg_s      (cfg_lf),
        .clr_tgl_s  (tgl_lf[0]),
        .load_tgl_s (tgl_lf[1]),
        .load_val   (load_val),
        .cnt_gray   (cnt_gray),
        .pend       (pend_lf),
        .wdt_rst    (wdt_rst)
    );

    wdt_cdc_sync #(.W(CNT_W+1), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_back (
        .clk (clk_sys), .rst (rst_sys), .d ({pend_lf, cnt_gray}), .q (back_sys)
    );

    // R8: with the mask bit clear the interrupt pin stays low
    a_r8_mask_blocks: assert property (@(posedge clk_sys) disable iff (rst_sys)
        (wr_en && bus_addr == A_MASK && !wr_data[0]) |=> !irq);
endmodule

// File: tb/match_wdt_tb.sv
module match_wdt_tb;
    localparam logic [2:0] AD_CTRL = 3'd0, AD_MATCH = 3'd1, AD_IGN = 3'd2, AD_LOCK = 3'd3,
                           AD_INTR = 3'd4, AD_MASK = 3'd5, AD_COUNT = 3'd6;

    logic        clk_sys = 1'b0, clk_lf = 1'b0;
    logic        rst_sys = 1'b1, rst_lf = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        irq, wdt_rst;

    int checks = 0, fails = 0;
    int rst_pulses = 0, irq_hits = 0;

    always #5 clk_sys = ~clk_sys;
    always #35 clk_lf = ~clk_lf;

    match_wdt u_dut (
        .clk_sys (clk_sys), .rst_sys (rst_sys), .clk_lf (clk_lf), .rst_lf (rst_lf),
        .wr_en (wr_en), .bus_addr (bus_addr), .wr_data (wr_data),
        .rd_data (rd_data), .irq (irq), .wdt_rst (wdt_rst)
    );

    always @(negedge clk_lf) if (!rst_lf && wdt_rst) rst_pulses++;
    always @(negedge clk_sys) if (!rst_sys && irq) irq_hits++;

    task automatic check_eq(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_in(string req, int act, int lo, int hi);
        checks++;
        if (act < lo || act > hi) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic bus_write(logic [2:0] a, logic [15:0] d);
        @(negedge clk_sys);
        wr_en = 1'b1; bus_addr = a; wr_data = d;
        @(negedge clk_sys);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(logic [2:0] a, output int d);
        @(negedge clk_sys);
        bus_addr = a;
        #1 d = int'(rd_data);
    endtask

    task automatic wait_lf(int n);
        repeat (n) @(posedge clk_lf);
        @(negedge clk_sys);
    endtask

    task automatic do_reset();
        rst_sys = 1'b1; rst_lf = 1'b1; wr_en = 1'b0;
        repeat (4) @(posedge clk_lf);
        @(negedge clk_lf) rst_lf = 1'b0;
        @(negedge clk_sys) rst_sys = 1'b0;
    endtask

    task automatic open_lock();
        bus_write(AD_LOCK, 16'h0);
        bus_write(AD_LOCK, 16'h0);
    endtask

    task automatic t_defaults();
        int v;
        do_reset();
        wait_lf(3);
        bus_read(AD_COUNT, v); check_eq("R1 count", v, 0);
        bus_read(AD_MATCH, v); check_eq("R1 match", v, 4096);
        bus_read(AD_IGN, v);   check_eq("R1 ignore", v, 0);
        bus_read(AD_LOCK, v);  check_eq("R1 lock", v, 3);
        bus_read(AD_CTRL, v);  check_eq("R1 enable", v, 0);
        bus_read(AD_INTR, v);  check_eq("R1 pending", v, 0);
        check_eq("R1 irq", int'(irq), 0);
        check_eq("R1 wdt_rst", int'(wdt_rst), 0);
    endtask

    task automatic t_lock();
        int v;
        do_reset();
        bus_write(AD_MATCH, 16'd7);
        bus_read(AD_MATCH, v); check_eq("R9 locked write dropped", v, 4096);
        bus_write(AD_LOCK, 16'h0);
        bus_read(AD_LOCK, v); check_eq("R9 first unlock step", v, 2);
        bus_write(AD_MATCH, 16'd7);
        bus_read(AD_MATCH, v); check_eq("R9 half-open still locked", v, 4096);
        bus_write(AD_LOCK, 16'h0);
        bus_read(AD_LOCK, v); check_eq("R9 second unlock step", v, 0);
        bus_write(AD_MATCH, 16'd7);
        bus_read(AD_MATCH, v); check_eq("R9 open write taken", v, 7);
        bus_write(AD_LOCK, 16'h3);
        bus_write(AD_MATCH, 16'd9);
        bus_write(AD_IGN, 16'd5);
        bus_write(AD_CTRL, 16'd1);
        bus_read(AD_MATCH, v); check_eq("R9 relocked match", v, 7);
        bus_read(AD_IGN, v);   check_eq("R9 relocked ignore", v, 0);
        bus_read(AD_CTRL, v);  check_eq("R9 relocked enable", v, 0);
    endtask

    task automatic t_count_load();
        int v;
        do_reset();
        open_lock();
        bus_write(AD_COUNT, 16'h1234);
        wait_lf(6);
        bus_read(AD_COUNT, v); check_eq("R11 load while disabled", v, 'h1234);
        wait_lf(10);
        bus_read(AD_COUNT, v); check_eq("R2 held while disabled", v, 'h1234);
        bus_write(AD_CTRL, 16'd1);
        wait_lf(20);
        bus_read(AD_COUNT, v); check_in("R2 counting while enabled", v, 'h1234 + 10, 'h1234 + 24);
        bus_write(AD_COUNT, 16'h0000);
        wait_lf(6);
        bus_read(AD_COUNT, v); check_in("R11 load dropped while enabled", v, 'h1234 + 16, 'h1234 + 40);
        bus_write(AD_CTRL, 16'd0);
        wait_lf(6);
        bus_write(AD_COUNT, 16'hFFFE);
        wait_lf(6);
        bus_write(AD_CTRL, 16'd1);
        wait_lf(12);
        bus_read(AD_COUNT, v); check_in("R2 wrap past 0xFFFF", v, 1, 'h20);
    endtask

    task automatic t_escalate();
        int v, base;
        do_reset();
        base = rst_pulses;
        open_lock();
        bus_write(AD_IGN, 16'd12);
        bus_write(AD_MATCH, 16'hFFF5);   // low 4 bits 5, upper bits must be ignored (R3)
        bus_write(AD_MASK, 16'd1);
        wait_lf(6);
        bus_write(AD_CTRL, 16'd1);
        wait_lf(12);
        check_eq("R5 no reset after first match", rst_pulses - base, 0);
        bus_read(AD_INTR, v); check_eq("R7 pending after match", v, 1);
        check_eq("R8 irq with mask set", int'(irq), 1);
        wait_lf(50);
        check_eq("R5 one reset pulse", rst_pulses - base, 1);
        bus_read(AD_COUNT, v); check_eq("R3 R4 R5 frozen at 5+2*16+1", v, 38);
        wait_lf(20);
        bus_read(AD_COUNT, v); check_eq("R6 counter stays frozen", v, 38);
        check_eq("R6 single pulse only", rst_pulses - base, 1);
    endtask

    task automatic t_mask_short();
        int v, base_r, base_i;
        do_reset();
        base_r = rst_pulses; base_i = irq_hits;
        open_lock();
        bus_write(AD_IGN, 16'd15);
        bus_write(AD_MATCH, 16'd1);
        wait_lf(6);
        bus_write(AD_CTRL, 16'd1);
        wait_lf(30);
        check_eq("R8 masked irq stays low", irq_hits - base_i, 0);
        bus_read(AD_INTR, v); check_eq("R8 pending despite mask", v, 1);
        check_eq("R8 reset despite mask", rst_pulses - base_r, 1);
        bus_read(AD_COUNT, v); check_eq("R3 R5 one-bit period frozen at 6", v, 6);
    endtask

    task automatic t_feed();
        int base_r, base_i;
        do_reset();
        base_r = rst_pulses; base_i = irq_hits;
        open_lock();
        bus_write(AD_IGN, 16'd12);
        bus_write(AD_MATCH, 16'd5);
        bus_write(AD_MASK, 16'd1);
        wait_lf(6);
        bus_write(AD_CTRL, 16'd1);
        for (int i = 0; i < 12; i++) begin
            wait_lf(10);
            bus_write(AD_INTR, 16'd1);
        end
        check_eq("R7 regular feeding avoids reset", rst_pulses - base_r, 0);
        check_in("R8 irq seen while fed", (irq_hits - base_i) > 0 ? 1 : 0, 1, 1);
        wait_lf(60);
        check_eq("R5 reset once feeding stops", rst_pulses - base_r, 1);
    endtask

    task automatic t_enable_clears();
        int v;
        do_reset();
        open_lock();
        bus_write(AD_IGN, 16'd12);
        bus_write(AD_MATCH, 16'd5);
        wait_lf(6);
        bus_write(AD_CTRL, 16'd1);
        wait_lf(12);
        bus_write(AD_CTRL, 16'd0);
        wait_lf(6);
        bus_read(AD_INTR, v); check_eq("R7 pending before feed", v, 1);
        bus_write(AD_INTR, 16'd1);
        wait_lf(6);
        bus_read(AD_INTR, v); check_eq("R7 feed clears pending", v, 0);
        bus_write(AD_COUNT, 16'd4);
        wait_lf(6);
        bus_write(AD_CTRL, 16'd1);
        wait_lf(8);
        bus_write(AD_CTRL, 16'd0);
        wait_lf(6);
        bus_read(AD_INTR, v); check_eq("R10 pending before re-enable", v, 1);
        bus_write(AD_COUNT, 16'd6);
        wait_lf(6);
        bus_write(AD_CTRL, 16'd1);
        wait_lf(6);
        bus_read(AD_INTR, v); check_eq("R10 enable clears pending", v, 0);
    endtask

    initial begin
        #3ms;
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        t_defaults();
        t_lock();
        t_count_load();
        t_escalate();
        t_mask_short();
        t_feed();
        t_enable_clears();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule